// File: doc/BRIEF.md
# Interrupt Controller with Keypad Trigger

This block gathers interrupt requests from up to sixteen peripheral sources into one flag register. It gates them through a per-source enable register and a master enable to drive a single processor interrupt request. Each source gives a one-cycle request pulse that latches its flag bit. Software reads the flags over a small register bus and clears them by writing ones. The request toward the processor is also held off while the processor's own interrupt-disable bit is set.

A second output, the wake signal, ends a processor halt. It looks only at whether any enabled flag is pending, so a halted processor resumes even when the master enable is off or the processor masks interrupts. A keypad trigger is built in. It watches ten active-low key lines against a selection mask and raises flag 12 when the chosen keys match, in either an any-key or an all-keys mode. Timer overflow pulses are expected on source lines 3 to 6.

Top module: `intc_top`

## Requirements
- R1: A pulse on `src_req[n]` sets flag bit n at the next clock edge and leaves every other flag bit unchanged.
- R2: A bus write to address 1 (flag register) clears each flag bit whose data bit is 1 and leaves bits written 0 unchanged.
- R3: When a source sets a flag bit in the same cycle as a write clears it, the bit ends up set.
- R4: `irq_out` is 1 exactly when (enable & flag) is non-zero, bit 0 of the master register (address 2) is 1, and `cpu_irq_mask` is 0.
- R5: `wake_out` is 1 exactly when (enable & flag) is non-zero, whatever the master register and `cpu_irq_mask` hold.
- R6: After reset, all four registers read 0 and both outputs are 0. The enable register (address 0) reads back all 16 bits written. The master register keeps only bit 0, and the key control register (address 3) keeps only bits 15, 14 and 9:0. Every other bit of these two reads 0.
- R7: In any-key mode (key control bit 15 = 0), with bit 14 = 1, the keypad sets flag bit 12 when at least one key selected in bits 9:0 is pressed. A key is pressed when its `keys_n` bit is 0.
- R8: In all-keys mode (key control bit 15 = 1), the keypad sets flag bit 12 only when every selected key is pressed. An empty selection never matches.
- R9: With key control bit 14 = 0, no key pattern sets flag bit 12.
- R10: The keypad sets flag bit 12 only on the cycle its match condition becomes true. Keys that stay held after software clears the flag do not set it again until the match ends and starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 enable, 1 flag, 2 master, 3 key control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| src_req | input | 16 | One-cycle source request pulses, one per flag bit |
| keys_n | input | 10 | Key states, 0 = pressed |
| cpu_irq_mask | input | 1 | Processor interrupt-disable bit |
| irq_out | output | 1 | Interrupt request to the processor |
| wake_out | output | 1 | Halt wake request |

## Verification
The bench checks that wake rises with the master enable off and with the processor mask set. A design that gated wake like the interrupt would leave a halted processor asleep. It holds a key down across a flag clear to catch level-triggered keypad logic, which would set the flag again at once and cause an interrupt storm. It also collides a set and a clear on one bit, where the wrong priority loses an event. An all-keys mode with an empty mask is tried too, because a naive equality compare would match there and fire with no key pressed.

// File: rtl/intc_pkg.sv
// Package: shared register address codes and key-control field positions.
// Assumes a two-bit register address on the bus.
package intc_pkg;
    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_FLAG   = 2'd1,
        REG_MASTER = 2'd2,
        REG_KEYCTL = 2'd3
    } reg_sel_e;

    localparam int KEY_ALL_BIT = 15;  // 1: all selected keys, 0: any selected key
    localparam int KEY_EN_BIT  = 14;  // keypad trigger enable
endpackage

// File: rtl/intc_keypad.sv
// Keypad trigger: compares active-low key lines against the selection mask
// in the key control word and gives a one-cycle pulse when the match begins.
// Assumes keys_n is already synchronous to clk.
module intc_keypad #(
    parameter int NKEYS = 10,
    parameter int CTL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] key_ctl,
    input  logic [NKEYS-1:0] keys_n,
    output logic             key_pulse
);
    import intc_pkg::*;

    logic [NKEYS-1:0] sel;
    logic [NKEYS-1:0] pressed;
    logic             match_now;
    logic             match_q;

    // Evaluate the selected-key match as a level.
    always_comb begin
        sel     = key_ctl[NKEYS-1:0];
        pressed = ~keys_n & sel;
        if (!key_ctl[KEY_EN_BIT])
            match_now = 1'b0;
        else if (key_ctl[KEY_ALL_BIT])
            match_now = (sel != '0) && (pressed == sel);
        else
            match_now = |pressed;
    end

    // Remember last cycle's match level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_now;
    end

    assign key_pulse = match_now & ~match_q;

    // R10: a pulse never lasts two cycles in a row
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        key_pulse |=> !key_pulse);
endmodule

// File: rtl/intc_flags.sv
// Flag register: set by source pulses, cleared by write-one-to-clear.
// A set beats a clear of the same bit in the same cycle.
module intc_flags #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] flag_q
);
    // Update pending flags, giving sets priority over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_vec) | set_vec;
    end

    // R1: every requested bit is pending the cycle after
    a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));
    // R1: no bit rises without a request
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));
    // R2: cleared bits with no concurrent set are gone
    a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((flag_q & $past(clr_vec) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/intc_req.sv
// Request gating: builds the processor interrupt and the halt wake from
// pending enabled flags. Wake ignores master enable and the processor mask.
module intc_req #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] enable_q,
    input  logic [NSRC-1:0] flag_q,
    input  logic            master_on,
    input  logic            cpu_irq_mask,
    output logic            irq,
    output logic            wake
);
    logic pending;

    // Combine pending state with the two gates.
    always_comb begin
        pending = |(enable_q & flag_q);
        wake    = pending;
        irq     = pending & master_on & ~cpu_irq_mask;
    end

    // R4: a request never escapes a closed gate
    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (master_on && !cpu_irq_mask && wake));
    // R5: wake follows pending work with the gates closed
    a_r5_wake_ungated: assert property (@(posedge clk) disable iff (!rst_n)
        (|(enable_q & flag_q) && !master_on) |-> wake);
endmodule

// File: rtl/intc_top.sv
// Interrupt controller top: register bus, enable/master/key-control state,
// flag register, keypad trigger and request gating.
// Assumes a single-cycle write strobe and combinational read.
module intc_top #(
    parameter int NSRC         = 16,
    parameter int NKEYS        = 10,
    parameter int KEY_FLAG_BIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [NSRC-1:0]  bus_wdata,
    output logic [NSRC-1:0]  bus_rdata,
    input  logic [NSRC-1:0]  src_req,
    input  logic [NKEYS-1:0] keys_n,
    input  logic             cpu_irq_mask,
    output logic             irq_out,
    output logic             wake_out
);
    import intc_pkg::*;

    localparam logic [NSRC-1:0] KEYCTL_KEEP =
        NSRC'((1 << KEY_ALL_BIT) | (1 << KEY_EN_BIT) | ((1 << NKEYS) - 1));

    logic [NSRC-1:0] enable_q;
    logic [NSRC-1:0] keyctl_q;
    logic            master_q;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic            key_pulse;

    // Hold the software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            keyctl_q <= '0;
            master_q <= 1'b0;
        end else if (bus_wr) begin
            case (reg_sel_e'(bus_addr))
                REG_ENABLE: enable_q <= bus_wdata;
                REG_MASTER: master_q <= bus_wdata[0];
                REG_KEYCTL: keyctl_q <= bus_wdata & KEYCTL_KEEP;
                default:    ;
            endcase
        end
    end

    // Form flag set and clear vectors from sources, keypad and bus.
    always_comb begin
        set_vec = src_req;
        set_vec[KEY_FLAG_BIT] = src_req[KEY_FLAG_BIT] | key_pulse;
        clr_vec = (bus_wr && reg_sel_e'(bus_addr) == REG_FLAG) ? bus_wdata : '0;
    end

    // Select the register addressed for read.
    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_ENABLE: bus_rdata = enable_q;
            REG_FLAG:   bus_rdata = flag_q;
            REG_MASTER: bus_rdata = {{(NSRC-1){1'b0}}, master_q};
            default:    bus_rdata = keyctl_q;
        endcase
    end

    intc_keypad #(.NKEYS(NKEYS), .CTL_W(NSRC)) u_keypad (
        .clk(clk), .rst_n(rst_n), .key_ctl(keyctl_q),
        .keys_n(keys_n), .key_pulse(key_pulse)
    );

    intc_flags #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_vec(clr_vec), .flag_q(flag_q)
    );

    intc_req #(.NSRC(NSRC)) u_req (
        .clk(clk), .rst_n(rst_n), .enable_q(enable_q), .flag_q(flag_q),
        .master_on(master_q), .cpu_irq_mask(cpu_irq_mask),
        .irq(irq_out), .wake(wake_out)
    );

    // R6: bits outside the key-control fields never hold a 1
    a_r6_keyctl_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (keyctl_q & ~KEYCTL_KEEP) == '0);
    // R3: a set colliding with a clear survives
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & clr_vec)) |=> ((flag_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

// File: tb/intc_top_tb.sv
module intc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] src_req = '0;
    logic [9:0]  keys_n = '1;
    logic        cpu_irq_mask = 1'b0;
    logic        irq_out;
    logic        wake_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    intc_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .keys_n(keys_n), .cpu_irq_mask(cpu_irq_mask),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    // {all_mode, select[9:0], keys_n[9:0], expect_flag12}
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 10'h003, 10'h3FE, 1'b1},
        {1'b0, 10'h003, 10'h3FB, 1'b0},
        {1'b1, 10'h003, 10'h3FE, 1'b0},
        {1'b1, 10'h003, 10'h3FC, 1'b1},
        {1'b1, 10'h000, 10'h000, 1'b0},
        {1'b0, 10'h000, 10'h000, 1'b0},
        {1'b1, 10'h201, 10'h1FE, 1'b1},
        {1'b0, 10'h200, 10'h1FF, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [15:0] v);
        src_req = v;
        @(negedge clk);
        src_req = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R6 reset reg", d, 16'h0000);
        end
        check("R6 reset outputs", {14'd0, irq_out, wake_out}, 16'h0000);

        // R7/R8: keypad match table
        for (int i = 0; i < NV; i++) begin
            keys_n = '1;
            wr(2'd3, {VEC[i][21], 1'b1, 4'h0, VEC[i][20:11]});
            @(negedge clk);
            wr(2'd1, 16'hFFFF);
            keys_n = VEC[i][10:1];
            @(negedge clk);
            rd(2'd1, d);
            check(VEC[i][21] ? "R8 all-keys match" : "R7 any-key match", d, {3'b0, VEC[i][0], 12'h000});
            keys_n = '1;
            @(negedge clk);
        end

        // R9: trigger disabled
        wr(2'd3, 16'h0003);
        wr(2'd1, 16'hFFFF);
        keys_n = 10'h3FC;
        repeat (2) @(negedge clk);
        rd(2'd1, d);
        check("R9 disabled keypad", d, 16'h0000);
        keys_n = '1;

        // R10: held key does not re-set after clear
        wr(2'd3, 16'h4001);
        @(negedge clk);
        keys_n = 10'h3FE;
        @(negedge clk);
        rd(2'd1, d);
        check("R10 first press", d, 16'h1000);
        wr(2'd1, 16'h1000);
        repeat (3) @(negedge clk);
        rd(2'd1, d);
        check("R10 held key no refire", d, 16'h0000);
        keys_n = '1;
        @(negedge clk);
        keys_n = 10'h3FE;
        @(negedge clk);
        rd(2'd1, d);
        check("R10 second press", d, 16'h1000);
        keys_n = '1;
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'hFFFF);

        // R1: source pulses accumulate
        pulse(16'h0008);
        rd(2'd1, d);
        check("R1 set bit 3", d, 16'h0008);
        pulse(16'h0040);
        rd(2'd1, d);
        check("R1 set bit 6 keeps 3", d, 16'h0048);

        // R2: write-one-to-clear
        wr(2'd1, 16'h0040);
        rd(2'd1, d);
        check("R2 clear bit 6 only", d, 16'h0008);

        // R3: set and clear collide on bit 5
        src_req = 16'h0020;
        wr(2'd1, 16'h0020);
        src_req = '0;
        rd(2'd1, d);
        check("R3 set wins", d, 16'h0028);

        // R6 readback masking
        wr(2'd0, 16'hA5C3);
        rd(2'd0, d);
        check("R6 enable readback", d, 16'hA5C3);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, d);
        check("R6 master keeps bit0", d, 16'h0001);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, d);
        check("R6 keyctl fields", d, 16'hC3FF);
        wr(2'd3, 16'h0000);

        // R4/R5: gating (flags now 0x0028)
        wr(2'd0, 16'h0008);
        wr(2'd2, 16'h0000);
        #1;
        check("R4 master off", {15'd0, irq_out}, 16'h0000);
        check("R5 wake with master off", {15'd0, wake_out}, 16'h0001);
        wr(2'd2, 16'h0001);
        #1;
        check("R4 all gates open", {15'd0, irq_out}, 16'h0001);
        cpu_irq_mask = 1'b1;
        #1;
        check("R4 cpu mask blocks", {15'd0, irq_out}, 16'h0000);
        check("R5 wake with cpu mask", {15'd0, wake_out}, 16'h0001);
        cpu_irq_mask = 1'b0;
        wr(2'd0, 16'h0010);
        #1;
        check("R4 not enabled", {15'd0, irq_out}, 16'h0000);
        check("R5 no wake when not enabled", {15'd0, wake_out}, 16'h0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule